// File: doc/BRIEF.md
# Dithered 12-bit PWM Channel

This block drives one PWM channel with 12 bits of duty resolution. It does not use a single wide compare. One PWM period of 4096 steps is cut into 16 subsections of 256 steps. Inside every subsection an 8-bit base pulse starts at step 0, and its width is the upper eight duty bits. A 4-bit rate multiplier takes the lower four duty bits and picks some subsections, spread evenly across the period. Each picked subsection gets one extra high step. The average duty therefore has 12-bit precision, while the ripple stays at the subsection rate.

A new duty word, a change on the output-disable input and a channel clear all take effect only at a period boundary. A period boundary is the clock edge on which the step counter wraps. A channel that is not driving reports this on its enable output so that the pad can go to high impedance. After reset or after a clear, the channel stays undriven until a duty word is written. The serial front end that assembles the duty word sits outside this block and delivers a whole 12-bit word with a one-cycle write strobe.

Top module: `dpwm_ch`

## Requirements
- R1: The synchronous reset (`rst_n` low) sets the step counter to zero. One step lasts PRESCALE (default 2) clocks. One period is 16 x 256 = 4096 steps (8192 clocks), and periods follow each other with no gap.
- R2: In subsection j (bits 11:8 of the step counter), the output is high on steps 0 .. U-1 of that subsection, where U is `wr_duty[11:4]` of the duty in use. It is low on the remaining steps, apart from the extra step of R3.
- R3: Let N be `wr_duty[3:0]`. Subsection j gets one extra high step, step U, exactly when the 4-bit reversal of j is less than N. This stretches exactly N subsections; for example N=1 stretches subsection 0 and N=8 stretches all even subsections.
- R4: A duty of 0x000 keeps the output low for the whole period. A stretched subsection with U=255 is high on all 256 of its steps.
- R5: A word written with `wr_en` is used from the next period boundary onward. A write on the last clock edge of a period is still used for the period that follows, and the current period is never changed.
- R6: `oe_dis` is sampled on the last edge of each period. If it is high, the next period is not driven. The duty word is kept, and driving resumes after a period whose final sample was low.
- R7: If `clr_n` is low on any edge of a period, the period still finishes as programmed. On its last edge the duty word and any pending write are cleared and the channel stops driving.
- R8: If `clr_n` is still low on that last edge, the counters hold at zero. The edge that first sees `clr_n` high releases the hold, and counting restarts on the edge after it.
- R9: After reset or a clear, the channel stays undriven until a write is accepted. Writes are ignored while `clr_n` is low, while the counters are held, and between a clear request and the boundary that carries it out.
- R10: While the channel is not driving, `pwm_oe` is 0 and `pwm_lvl` is 0. After reset nothing is pending.
- R11: Reset is synchronous: the outputs change only on the first rising edge that samples `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that the step prescaler divides |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Active-low channel clear, carried out at the period boundary |
| oe_dis | input | 1 | High to leave the next period undriven |
| wr_en | input | 1 | One-cycle strobe that writes `wr_duty` |
| wr_duty | input | 12 | Duty word: bits 11:4 set the base width, bits 3:0 set the stretch count |
| pwm_lvl | output | 1 | PWM level; 0 whenever the channel is not driving |
| pwm_oe | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The bench counts high clocks in each of the 16 subsections and compares them against stretch masks worked out by hand for several low nibbles. A multiplier that reversed the wrong bits, or that compared with <= instead of <, would put the extra step in the wrong subsections or add one too many. The bench writes duties in the middle of a period, raises `oe_dis` in the middle of a period and pulses `clr_n` in the middle of a period. A design that applied any of these at once, instead of at the boundary, would corrupt the period that is running. The bench also checks that a write landing between a clear request and its boundary is dropped. It releases a held clear and checks that the next period is aligned to the step grid, which catches an off-by-one restart. Finally it applies reset mid-period to confirm that the reset does not act asynchronously.

// File: rtl/dpwm_pkg.sv
// Package: types shared by the dithered PWM channel modules.
// Assumes: one step pulse per prescaled clock; the period-end pulse is only
// raised together with a step pulse.
package dpwm_pkg;

    // Timing events produced by the time base for one clock cycle
    typedef struct packed {
        logic step_tick;   // counter advances on this edge
        logic cyc_end;     // counter wraps to zero on this edge
    } dpwm_tick_t;

endpackage

// File: rtl/dpwm_timebase.sv
// Module: dpwm_timebase
// Divides the clock by PRESCALE into steps. It counts steps in a free-running
// counter whose low BASE_W bits give the step inside a subsection and whose high
// FRAC_W bits give the subsection index.
// Assumes: while hold is high, the counter and the prescaler are kept at zero
// and no events are raised.
module dpwm_timebase #(
    parameter int unsigned BASE_W   = 8,
    parameter int unsigned FRAC_W   = 4,
    parameter int unsigned PRESCALE = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold,
    output logic [BASE_W-1:0]      step,
    output logic [FRAC_W-1:0]      sub,
    output dpwm_pkg::dpwm_tick_t   tick
);
    localparam int unsigned POS_W = BASE_W + FRAC_W;

    logic             step_tick;
    logic [POS_W-1:0] pos_q;

    generate
        if (PRESCALE <= 1) begin : g_nodiv
            assign step_tick = !hold;
        end else begin : g_div
            localparam int unsigned      DIV_W    = $clog2(PRESCALE);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);
            logic [DIV_W-1:0] div_q;

            // Prescaler: counts clocks within one step
            always_ff @(posedge clk) begin
                if (!rst_n || hold)
                    div_q <= '0;
                else if (div_q == DIV_LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign step_tick = !hold && (div_q == DIV_LAST);
        end
    endgenerate

    // Position counter: step within subsection plus subsection index
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            pos_q <= '0;
        else if (step_tick)
            pos_q <= pos_q + 1'b1;
    end

    assign step           = pos_q[BASE_W-1:0];
    assign sub            = pos_q[POS_W-1:BASE_W];
    assign tick.step_tick = step_tick;
    assign tick.cyc_end   = step_tick && (&pos_q);

endmodule

// File: rtl/dpwm_ratemul.sv
// Module: dpwm_ratemul
// Rate multiplier that picks which subsections are stretched by one step.
// Subsection j is stretched when the bit-reversed j is below frac, so exactly
// frac of the 2**FRAC_W subsections are picked and they are spread evenly.
// Assumes: purely combinational; sub is the live subsection index.
module dpwm_ratemul #(
    parameter int unsigned FRAC_W = 4
) (
    input  logic [FRAC_W-1:0] sub,
    input  logic [FRAC_W-1:0] frac,
    output logic              stretch
);
    logic [FRAC_W-1:0] sub_rev;

    for (genvar b = 0; b < FRAC_W; b++) begin : g_rev
        assign sub_rev[b] = sub[FRAC_W-1-b];
    end

    assign stretch = (sub_rev < frac);

endmodule

// File: rtl/dpwm_shaper.sv
// Module: dpwm_shaper
// Base PWM compare inside one subsection. The output is high on steps below
// base, and also on step base when the subsection is stretched.
// Assumes: drive low forces the level low so the pad sees a quiet line.
module dpwm_shaper #(
    parameter int unsigned BASE_W = 8
) (
    input  logic [BASE_W-1:0] step,
    input  logic [BASE_W-1:0] base,
    input  logic              stretch,
    input  logic              drive,
    output logic              lvl
);
    // Level decision for the current step
    always_comb begin
        lvl = 1'b0;
        if (drive) begin
            if (step < base)
                lvl = 1'b1;
            else if ((step == base) && stretch)
                lvl = 1'b1;
        end
    end

endmodule

// File: rtl/dpwm_ctrl.sv
// Module: dpwm_ctrl
// Holds the pending and active duty words, the armed flag (channel written
// since the last clear), the sampled output-disable flag and the clear and hold
// state. Every change that is visible at the outputs happens on a period-end edge.
// Assumes: cyc_end is low while hold is high.
module dpwm_ctrl #(
    parameter int unsigned DUTY_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              oe_dis,
    input  logic              wr_en,
    input  logic [DUTY_W-1:0] wr_duty,
    input  logic              cyc_end,
    output logic [DUTY_W-1:0] duty_act,
    output logic              drive,
    output logic              hold
);
    logic [DUTY_W-1:0] pend_q;
    logic [DUTY_W-1:0] pend_d;
    logic              pend_vld_q;
    logic              pend_vld_d;
    logic              armed_q;
    logic              oe_off_q;
    logic              clr_req_q;
    logic              wr_ok;
    logic              do_clr;

    assign wr_ok      = wr_en && clr_n && !clr_req_q && !hold;
    assign pend_d     = wr_ok ? wr_duty : pend_q;
    assign pend_vld_d = wr_ok || pend_vld_q;
    assign do_clr     = cyc_end && (clr_req_q || !clr_n);

    // Clear request: remembers a low clr_n until the period ends
    always_ff @(posedge clk) begin
        if (!rst_n || do_clr || hold)
            clr_req_q <= 1'b0;
        else if (!clr_n)
            clr_req_q <= 1'b1;
    end

    // Hold: counters stay parked while the clear input remains low
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= 1'b0;
        else if (do_clr)
            hold <= !clr_n;
        else if (hold && clr_n)
            hold <= 1'b0;
    end

    // Duty words and armed flag: writes are staged, promoted at period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            duty_act   <= '0;
            armed_q    <= 1'b0;
        end else if (do_clr) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            duty_act   <= '0;
            armed_q    <= 1'b0;
        end else if (cyc_end) begin
            pend_vld_q <= 1'b0;
            if (pend_vld_d) begin
                duty_act <= pend_d;
                armed_q  <= 1'b1;
            end
        end else begin
            pend_q     <= pend_d;
            pend_vld_q <= pend_vld_d;
        end
    end

    // Output-disable sample: taken once per period on its last edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_off_q <= 1'b0;
        else if (cyc_end)
            oe_off_q <= oe_dis;
    end

    assign drive = armed_q && !oe_off_q;

endmodule

// File: rtl/dpwm_ch.sv
// Module: dpwm_ch (top)
// One dithered PWM channel: time base, rate multiplier, base-width compare and
// boundary-synchronous control. pwm_oe low asks the pad to float the pin.
// Assumes: the duty word arrives whole with a one-cycle wr_en strobe.
module dpwm_ch #(
    parameter int unsigned BASE_W   = 8,
    parameter int unsigned FRAC_W   = 4,
    parameter int unsigned PRESCALE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_n,
    input  logic                     oe_dis,
    input  logic                     wr_en,
    input  logic [BASE_W+FRAC_W-1:0] wr_duty,
    output logic                     pwm_lvl,
    output logic                     pwm_oe
);
    localparam int unsigned DUTY_W = BASE_W + FRAC_W;

    logic [BASE_W-1:0]    step_w;
    logic [FRAC_W-1:0]    sub_w;
    dpwm_pkg::dpwm_tick_t tick_w;
    logic [DUTY_W-1:0]    duty_w;
    logic                 drive_w;
    logic                 hold_w;
    logic                 stretch_w;

    dpwm_timebase #(
        .BASE_W  (BASE_W),
        .FRAC_W  (FRAC_W),
        .PRESCALE(PRESCALE)
    ) i_timebase (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (hold_w),
        .step (step_w),
        .sub  (sub_w),
        .tick (tick_w)
    );

    dpwm_ctrl #(
        .DUTY_W(DUTY_W)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .oe_dis  (oe_dis),
        .wr_en   (wr_en),
        .wr_duty (wr_duty),
        .cyc_end (tick_w.cyc_end),
        .duty_act(duty_w),
        .drive   (drive_w),
        .hold    (hold_w)
    );

    dpwm_ratemul #(
        .FRAC_W(FRAC_W)
    ) i_ratemul (
        .sub    (sub_w),
        .frac   (duty_w[FRAC_W-1:0]),
        .stretch(stretch_w)
    );

    dpwm_shaper #(
        .BASE_W(BASE_W)
    ) i_shaper (
        .step   (step_w),
        .base   (duty_w[DUTY_W-1:FRAC_W]),
        .stretch(stretch_w),
        .drive  (drive_w),
        .lvl    (pwm_lvl)
    );

    assign pwm_oe = drive_w;

endmodule

// File: rtl/dpwm_ch_chk.sv
// Module: dpwm_ch_chk
// Property checker for dpwm_ch, attached by bind. It watches the step counter,
// the hold state, the active duty word and the outputs.
// Assumes: reset is held for at least two clock edges.
module dpwm_ch_chk #(
    parameter int unsigned BASE_W = 8,
    parameter int unsigned FRAC_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [BASE_W-1:0]        step,
    input logic [FRAC_W-1:0]        sub,
    input logic                     step_tick,
    input logic                     hold,
    input logic                     stretch,
    input logic [BASE_W+FRAC_W-1:0] duty_act,
    input logic                     pwm_lvl,
    input logic                     pwm_oe
);
    localparam int unsigned POS_W = BASE_W + FRAC_W;

    logic [POS_W-1:0] pos;
    assign pos = {sub, step};

    p_pos_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> (pos == $past(pos) + POS_W'(1)));

    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_oe |-> !pwm_lvl);

    p_zero_duty_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> !pwm_lvl);

    p_full_stretch_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe && (&duty_act[POS_W-1:FRAC_W]) && stretch) |-> pwm_lvl);

    p_duty_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_act) |-> (pos == '0));

    p_oe_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwm_oe) |-> (pos == '0));

    p_hold_parks_counter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (pos == '0));

    p_no_step_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !step_tick);

endmodule

bind dpwm_ch dpwm_ch_chk #(
    .BASE_W(BASE_W),
    .FRAC_W(FRAC_W)
) i_dpwm_ch_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step_w),
    .sub      (sub_w),
    .step_tick(tick_w.step_tick),
    .hold     (hold_w),
    .stretch  (stretch_w),
    .duty_act (duty_w),
    .pwm_lvl  (pwm_lvl),
    .pwm_oe   (pwm_oe)
);

// File: tb/test_dpwm_ch.sv
// Bench for dpwm_ch. It walks a table of duty words one period each, then runs
// directed tests for output disable, clear, hold, rewrite and reset.
module test_dpwm_ch;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_CLK    = 8192;   // 4096 steps x 2 clocks
    localparam int SUB_CLK    = 512;    // 256 steps x 2 clocks
    localparam int N_VEC      = 8;
    localparam int WDOG_CLK   = 190000;

    // {duty, total high steps per period, stretched-subsection mask}
    localparam logic [43:0] VEC [N_VEC] = '{
        {12'h000, 16'd0,    16'h0000},
        {12'h001, 16'd1,    16'h0001},
        {12'h005, 16'd5,    16'h1115},
        {12'h008, 16'd8,    16'h5555},
        {12'h00F, 16'd15,   16'h7FFF},
        {12'h804, 16'd2052, 16'h1111},
        {12'hFF1, 16'd4081, 16'h0001},
        {12'hFFF, 16'd4095, 16'h7FFF}
    };

    logic        clk = 1'b0;
    logic        rst_n, clr_n, oe_dis, wr_en;
    logic [11:0] wr_duty;
    logic        pwm_lvl, pwm_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int hi [16];
    int oe_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpwm_ch i_dpwm_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .oe_dis (oe_dis),
        .wr_en  (wr_en),
        .wr_duty(wr_duty),
        .pwm_lvl(pwm_lvl),
        .pwm_oe (pwm_oe)
    );

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WDOG_CLK) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run exceeded %0d clocks", WDOG_CLK);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    // One period from its first negedge; samples outputs, drives inputs
    task automatic run_cycle(input logic [11:0] d, input int wr_at,
                             input int clr_lo_end, input logic oe_val);
        for (int j = 0; j < 16; j++) hi[j] = 0;
        oe_cnt = 0;
        for (int i = 0; i < CYC_CLK; i++) begin
            if (pwm_lvl) hi[i / SUB_CLK]++;
            if (pwm_oe) oe_cnt++;
            wr_en   = (i == wr_at);
            wr_duty = d;
            clr_n   = !(i < clr_lo_end);
            oe_dis  = oe_val;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic check_on(input logic [11:0] d, input int tot,
                            input logic [15:0] mask, input string tag);
        int sum = 0;
        bit bad = 0;
        n_checks++;
        if (oe_cnt != CYC_CLK) begin
            bad = 1;
            $display("FAIL %s: driven clocks actual=%0d expected=%0d", tag, oe_cnt, CYC_CLK);
        end
        for (int j = 0; j < 16; j++) begin
            int exp_j;
            exp_j = 2 * (int'(d[11:4]) + int'(mask[j]));
            sum += hi[j];
            if (!bad && hi[j] != exp_j) begin
                bad = 1;
                $display("FAIL %s: duty=%h sub %0d high clocks actual=%0d expected=%0d",
                         tag, d, j, hi[j], exp_j);
            end
        end
        if (!bad && sum != 2 * tot) begin
            bad = 1;
            $display("FAIL %s: duty=%h total high actual=%0d expected=%0d", tag, d, sum, 2 * tot);
        end
        if (bad) n_fails++;
    endtask

    task automatic check_off(input string tag);
        int sum = 0;
        n_checks++;
        for (int j = 0; j < 16; j++) sum += hi[j];
        if (oe_cnt != 0 || sum != 0) begin
            n_fails++;
            $display("FAIL %s: driven=%0d high=%0d expected driven=0 high=0", tag, oe_cnt, sum);
        end
    endtask

    initial begin
        rst_n   = 1'b0;
        clr_n   = 1'b1;
        oe_dis  = 1'b0;
        wr_en   = 1'b0;
        wr_duty = '0;
        repeat (4) @(negedge clk);

        // R10: reset state is undriven and low
        n_checks++;
        if (pwm_oe !== 1'b0 || pwm_lvl !== 1'b0) begin
            n_fails++;
            $display("FAIL R10 reset state: oe=%b lvl=%b expected oe=0 lvl=0", pwm_oe, pwm_lvl);
        end
        rst_n = 1'b1;   // this negedge is step 0 of the first period (R1)

        // Table walk: word i is written in period i and shown in period i+1 (R5)
        for (int i = 0; i <= N_VEC; i++) begin
            logic [11:0] d_w;
            d_w = (i < N_VEC) ? VEC[i][43:32] : 12'h000;
            run_cycle(d_w, (i < N_VEC) ? 0 : -1, 0, (i == N_VEC));
            if (i == 0)
                check_off("R10 R9 undriven before first write");
            else if (i < N_VEC)
                check_on(VEC[i-1][43:32], int'(VEC[i-1][31:16]), VEC[i-1][15:0],
                         "R1 R2 R3 R4 R5 table");
            else
                check_on(VEC[i-1][43:32], int'(VEC[i-1][31:16]), VEC[i-1][15:0],
                         "R6 still driven while oe_dis first rises");
        end

        // R6: period after oe_dis sampled high is undriven
        run_cycle(12'h000, -1, 0, 1'b0);
        check_off("R6 undriven after oe_dis");

        // R6 R7: duty kept; clear pulse leaves the running period intact
        run_cycle(12'h555, 200, 100, 1'b0);
        check_on(12'hFFF, 4095, 16'h7FFF, "R6 R7 duty kept, clear waits for boundary");

        // R7 R9: cleared at boundary, the late write is dropped
        run_cycle(12'h000, -1, 0, 1'b0);
        check_off("R7 R9 cleared and late write dropped");

        // R5 R9: the write period itself is still undriven
        run_cycle(12'h0F8, 0, 0, 1'b0);
        check_off("R5 R9 undriven in write period");

        // R3 R5: new word shown; clr_n held low all period to enter hold
        run_cycle(12'h000, -1, CYC_CLK, 1'b0);
        check_on(12'h0F8, 248, 16'h5555, "R3 R5 rewrite enables channel");

        // R8 R10: during hold the output is quiet and writes are refused
        begin
            bit bad = 0;
            n_checks++;
            for (int k = 0; k < 300; k++) begin
                if (pwm_oe || pwm_lvl) bad = 1;
                wr_en   = (k == 5);
                wr_duty = 12'hFFF;
                @(negedge clk);
            end
            wr_en = 1'b0;
            if (bad) begin
                n_fails++;
                $display("FAIL R8 R10 hold: output active actual=1 expected=0");
            end
        end
        clr_n = 1'b1;
        @(negedge clk);   // release edge; counting restarts on the next edge (R8)

        // R9: write made during hold was ignored; a fresh write is staged
        run_cycle(12'h2C3, 0, 0, 1'b0);
        check_off("R9 write during hold ignored");

        // R8: restart is aligned to the step grid
        run_cycle(12'h000, -1, 0, 1'b0);
        check_on(12'h2C3, 707, 16'h0111, "R8 R3 aligned restart");

        // R11: reset is synchronous
        n_checks++;
        rst_n = 1'b0;
        #1;
        if (pwm_oe !== 1'b1) begin
            n_fails++;
            $display("FAIL R11 before edge: oe actual=%b expected=1", pwm_oe);
        end
        n_checks++;
        @(negedge clk);
        if (pwm_oe !== 1'b0 || pwm_lvl !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 after edge: oe=%b lvl=%b expected oe=0 lvl=0", pwm_oe, pwm_lvl);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule